// File: doc/BRIEF.md
# Buffered Compare Timer with Match Flags

This block is a 16-bit timing core for a motor-control style PWM engine. A triangle counter runs from zero up to a programmable peak and back down again. It passes through two turning points: a peak event and a zero event. Three compare channels watch the counter. Each channel has a buffer register and a live compare register. Each channel also has a sticky match flag that software can poll.

Software can load a buffer through either of two bus addresses.

- **Deferred address:** the value waits in the buffer. It moves into the compare register at the turning point chosen by a 2-bit transfer-mode field, so all three channels change together without glitches.
- **Immediate address:** the value reaches the compare register at once.

A match flag sets whenever the counter equals its compare register. It is cleared with a handshake: software first reads the flag as one, then writes zero to it. A stray write of zero therefore cannot lose an event. Only 16-bit bus accesses have any effect.

Top module: `tmr_cmp_unit`

## Requirements
- R1: The 16-bit counter is at address 0x0. It resets to 0x0000. A 16-bit write loads it at the next edge, and a read returns it. A load also sets the counting direction to upward.
- R2: After reset, the three buffers (0x4+i) and the three compare registers (0xC+i, read-only) read 0xFFFF. The status register (0x3) reads 0x0000. The control register (0x2) reads 0x0000, meaning stopped with transfer mode "none". The peak register (0x1) reads 0xFFFF.
- R3: A 16-bit write to the deferred address 0x4+i updates buffer i only. Compare register i keeps its old value until a selected transfer event.
- R4: A 16-bit write to the immediate address 0x8+i loads both buffer i and compare register i at the same edge. The buffer also reads back at 0x8+i.
- R5: Match flag i is status bit i at 0x3. It sets at the edge that ends any cycle in which the counter equals compare register i, whether the counter is running or stopped.
- R6: A 16-bit write to 0x3 clears flag i only if all three of these hold:
  - bit i of the write data is 0;
  - a 16-bit read of 0x3 returned flag i as 1 earlier;
  - no status write has come between that read and this write.
  A zero written without such a read leaves the flag set.
- R7: Accesses with bus_wide low are ignored. They change no counter, buffer, compare or flag state, and they arm no clear.
- R8: Control bits [1:0] select the transfer point: 00 none, 01 peak event, 10 zero event, 11 both. At a selected event, every compare register takes its buffer's value at the same edge. An immediate write to a channel takes precedence over a transfer to that channel.
- R9: If a match occurs in the same cycle as a valid clear, the flag stays 1.
- R10: While control bit 2 is 1, the counter steps once per cycle.
  - Going up, it increments until it reaches or exceeds the peak register (0x1). It then raises the peak event and starts decrementing.
  - At 0 it raises the zero event and starts incrementing.
  - A peak of 0 holds the counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit access; 0 = byte access (ignored) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of a 16-bit read, otherwise 0 |

## Verification
The bench runs the counter through full triangles in each transfer mode. It samples the compare register in the cycles just before and just after a turning point. A design that transfers on the wrong event, or one cycle late, shows the stale or the new value at the wrong moment.

The clear handshake is checked in three ways:
- a bare zero write, which a naive design would honour;
- a read followed by a zero write, which a design that never arms would refuse;
- a clear that coincides with a standing match, which a design giving clear priority would drop.

Byte writes to the counter and to an immediate address must leave both unchanged. A design that ignores the access width would corrupt them.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CNT     = 4'h0;
  localparam logic [ADDR_W-1:0] A_PEAK    = 4'h1;
  localparam logic [ADDR_W-1:0] A_CTRL    = 4'h2;
  localparam logic [ADDR_W-1:0] A_STAT    = 4'h3;
  localparam logic [ADDR_W-1:0] A_BUF_DEF = 4'h4;
  localparam logic [ADDR_W-1:0] A_BUF_IMM = 4'h8;
  localparam logic [ADDR_W-1:0] A_CMP     = 4'hC;

  typedef enum logic [1:0] {
    XFER_NONE = 2'b00,
    XFER_PEAK = 2'b01,
    XFER_ZERO = 2'b10,
    XFER_BOTH = 2'b11
  } xfer_mode_e;

  typedef struct packed {
    logic       run;
    xfer_mode_e mode;
  } ctrl_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tmr_updown_cnt.sv
module tmr_updown_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] peak,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         peak_ev,
  output logic         zero_ev
);
  logic [W-1:0] cnt_q, cnt_nxt;
  logic         up_q, up_nxt;
  logic         cnt_en;

  // Turning points are taken from the present state.
  assign peak_ev = run && up_q && (cnt_q >= peak);
  assign zero_ev = run && !up_q && (cnt_q == '0);
  assign cnt_en  = ld_en || run;

  always_comb begin
    cnt_nxt = cnt_q;
    up_nxt  = up_q;
    if (ld_en) begin
      cnt_nxt = ld_val;
      up_nxt  = 1'b1;
    end else if (run) begin
      if (up_q) begin
        if (cnt_q >= peak) begin
          up_nxt  = 1'b0;
          cnt_nxt = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        end else begin
          cnt_nxt = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          up_nxt  = 1'b1;
          cnt_nxt = (peak == '0) ? '0 : W'(1);
        end else begin
          cnt_nxt = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
      up_q  <= up_nxt;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_def,
  input  logic         wr_imm,
  input  logic [W-1:0] wdata,
  input  logic         xfer,
  input  logic [W-1:0] cnt,
  input  logic         stat_rd,
  input  logic         stat_wr,
  input  logic         stat_wbit,
  output logic [W-1:0] bufr,
  output logic [W-1:0] cmp,
  output logic         flag
);
  logic [W-1:0] bufr_q, bufr_nxt;
  logic [W-1:0] cmp_q, cmp_nxt;
  logic         flag_q, flag_nxt;
  logic         armed_q, armed_nxt;
  logic         hit;

  assign hit = (cnt == cmp_q);

  always_comb begin
    bufr_nxt = bufr_q;
    if (wr_def || wr_imm) bufr_nxt = wdata;

    cmp_nxt = cmp_q;
    if (wr_imm)    cmp_nxt = wdata;
    else if (xfer) cmp_nxt = bufr_q;

    armed_nxt = armed_q;
    if (stat_wr)                armed_nxt = 1'b0;
    else if (stat_rd && flag_q) armed_nxt = 1'b1;

    flag_nxt = flag_q;
    if (hit)                                  flag_nxt = 1'b1;
    else if (stat_wr && !stat_wbit && armed_q) flag_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bufr_q  <= '1;
      cmp_q   <= '1;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      bufr_q  <= bufr_nxt;
      cmp_q   <= cmp_nxt;
      flag_q  <= flag_nxt;
      armed_q <= armed_nxt;
    end
  end

  assign bufr = bufr_q;
  assign cmp  = cmp_q;
  assign flag = flag_q;
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
  import tmr_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_wide,
  input  logic [3:0]        bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic rst_sync_n;
  logic acc_wr, acc_rd;
  logic cnt_ld, peak_wr, ctrl_wr, stat_wr, stat_rd;
  logic peak_ev, zero_ev, xfer;
  logic run;
  logic [1:0] mode_bits;
  logic [CNT_W-1:0] cnt_v;
  logic [CNT_W-1:0] peak_q, peak_nxt;
  ctrl_t            ctrl_q, ctrl_nxt;
  logic [N_CH-1:0][CNT_W-1:0] bufr_p, cmp_p;
  logic [N_CH-1:0]            flag_v;

  tmr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // Only 16-bit accesses reach any register.
  assign acc_wr  = bus_en && bus_wide && bus_we;
  assign acc_rd  = bus_en && bus_wide && !bus_we;
  assign cnt_ld  = acc_wr && (bus_addr == A_CNT);
  assign peak_wr = acc_wr && (bus_addr == A_PEAK);
  assign ctrl_wr = acc_wr && (bus_addr == A_CTRL);
  assign stat_wr = acc_wr && (bus_addr == A_STAT);
  assign stat_rd = acc_rd && (bus_addr == A_STAT);

  assign run       = ctrl_q.run;
  assign mode_bits = 2'(ctrl_q.mode);
  assign xfer      = (mode_bits[0] && peak_ev) || (mode_bits[1] && zero_ev);

  always_comb begin
    peak_nxt = peak_wr ? bus_wdata : peak_q;
    ctrl_nxt = ctrl_wr ? ctrl_t'(bus_wdata[CTRL_W-1:0]) : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      peak_q <= '1;
      ctrl_q <= '0;
    end else begin
      peak_q <= peak_nxt;
      ctrl_q <= ctrl_nxt;
    end
  end

  tmr_updown_cnt #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (run),
    .peak    (peak_q),
    .ld_en   (cnt_ld),
    .ld_val  (bus_wdata),
    .cnt     (cnt_v),
    .peak_ev (peak_ev),
    .zero_ev (zero_ev)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam logic [3:0] ADEF = A_BUF_DEF + 4'(i);
    localparam logic [3:0] AIMM = A_BUF_IMM + 4'(i);
    tmr_cmp_chan #(.W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_def    (acc_wr && (bus_addr == ADEF)),
      .wr_imm    (acc_wr && (bus_addr == AIMM)),
      .wdata     (bus_wdata),
      .xfer      (xfer),
      .cnt       (cnt_v),
      .stat_rd   (stat_rd),
      .stat_wr   (stat_wr),
      .stat_wbit (bus_wdata[i]),
      .bufr      (bufr_p[i]),
      .cmp       (cmp_p[i]),
      .flag      (flag_v[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (acc_rd) begin
      unique case (bus_addr)
        A_CNT:   bus_rdata = cnt_v;
        A_PEAK:  bus_rdata = peak_q;
        A_CTRL:  bus_rdata = CNT_W'(ctrl_q);
        A_STAT:  bus_rdata = CNT_W'(flag_v);
        default: bus_rdata = '0;
      endcase
      for (int i = 0; i < N_CH; i++) begin
        if (bus_addr == A_BUF_DEF + 4'(i) || bus_addr == A_BUF_IMM + 4'(i))
          bus_rdata = bufr_p[i];
        if (bus_addr == A_CMP + 4'(i))
          bus_rdata = cmp_p[i];
      end
    end
  end
endmodule

// File: rtl/tmr_cmp_unit_chk.sv
module tmr_cmp_unit_chk
  import tmr_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_en,
  input logic                       bus_we,
  input logic                       bus_wide,
  input logic [3:0]                 bus_addr,
  input logic [CNT_W-1:0]           bus_wdata,
  input logic                       run,
  input logic                       xfer,
  input logic [CNT_W-1:0]           cnt_v,
  input logic [N_CH-1:0][CNT_W-1:0] cmp_p,
  input logic [N_CH-1:0]            flag_v
);
  assert_cnt_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_wide && bus_addr == A_CNT) |=> cnt_v == $past(bus_wdata));

  assert_byte_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && !bus_wide && !run) |=> $stable(cnt_v));

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    assert_imm_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_wide && bus_addr == A_BUF_IMM + 4'(i))
        |=> cmp_p[i] == $past(bus_wdata));

    assert_cmp_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer && !(bus_en && bus_we && bus_wide && bus_addr == A_BUF_IMM + 4'(i)))
        |=> $stable(cmp_p[i]));

    assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_v == cmp_p[i]) |=> flag_v[i]);

    assert_clear_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_v[i]) |->
        $past(bus_en && bus_we && bus_wide && bus_addr == A_STAT && !bus_wdata[i]));
  end
endmodule

bind tmr_cmp_unit tmr_cmp_unit_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_wide  (bus_wide),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .run       (run),
  .xfer      (xfer),
  .cnt_v     (cnt_v),
  .cmp_p     (cmp_p),
  .flag_v    (flag_v)
);

// File: tb/tmr_cmp_unit_tb.sv
module tmr_cmp_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        bus_en, bus_we, bus_wide;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  tmr_cmp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector: write flag, wide flag, address, data (write data or expected read), requirement number.
  typedef struct packed {
    logic        we;
    logic        wide;
    logic [3:0]  addr;
    logic [15:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 4'h0, 16'h1234, 4'd1},
    '{1'b0, 1'b1, 4'h0, 16'h1234, 4'd1},
    '{1'b1, 1'b1, 4'h4, 16'hAAAA, 4'd3},
    '{1'b0, 1'b1, 4'h4, 16'hAAAA, 4'd3},
    '{1'b0, 1'b1, 4'hC, 16'hFFFF, 4'd3},
    '{1'b1, 1'b1, 4'h9, 16'h5555, 4'd4},
    '{1'b0, 1'b1, 4'hD, 16'h5555, 4'd4},
    '{1'b0, 1'b1, 4'h9, 16'h5555, 4'd4},
    '{1'b1, 1'b0, 4'h0, 16'hBEEF, 4'd7},
    '{1'b0, 1'b1, 4'h0, 16'h1234, 4'd7},
    '{1'b1, 1'b0, 4'hA, 16'h0123, 4'd7},
    '{1'b0, 1'b1, 4'hE, 16'hFFFF, 4'd7},
    '{1'b1, 1'b1, 4'h1, 16'h0004, 4'd10},
    '{1'b0, 1'b1, 4'h1, 16'h0004, 4'd10}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic wide = 1'b1);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_wide = wide; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wide = 1'b1;
  endtask

  // Read that spans an edge (a status read here arms the clear).
  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_wide = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  // Look at a register without letting a clock edge see the access.
  task automatic peek(input logic [3:0] a, output logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_wide = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [15:0] tri_exp [10];
    tri_exp = '{16'd1, 16'd2, 16'd3, 16'd4, 16'd3, 16'd2, 16'd1, 16'd0, 16'd1, 16'd2};
    bus_en = 0; bus_we = 0; bus_wide = 1; bus_addr = 0; bus_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2 reset state
    peek(4'h0, r); check("R1 counter reset", r, 16'h0000);
    for (int i = 0; i < 3; i++) begin
      peek(4'(4 + i), r);  check("R2 buffer reset", r, 16'hFFFF);
      peek(4'(12 + i), r); check("R2 compare reset", r, 16'hFFFF);
    end
    peek(4'h3, r); check("R2 status reset", r, 16'h0000);
    peek(4'h2, r); check("R2 control reset", r, 16'h0000);
    peek(4'h1, r); check("R2 peak reset", r, 16'hFFFF);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].we) wr(VEC[v].addr, VEC[v].data, VEC[v].wide);
      else begin
        rd(VEC[v].addr, r);
        check($sformatf("R%0d vector %0d", VEC[v].req, v), r, VEC[v].data);
      end
    end

    // R10 triangle and R8 peak transfer (mode 01)
    wr(4'h0, 16'h0000);
    wr(4'h4, 16'h0003);
    wr(4'h2, 16'h0005);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      peek(4'h0, r); check($sformatf("R10 triangle step %0d", k), r, tri_exp[k-1]);
      if (k == 4) begin peek(4'hC, r); check("R3 compare held before peak", r, 16'hFFFF); end
      if (k == 5) begin peek(4'hC, r); check("R8 peak transfer", r, 16'h0003); end
    end
    wr(4'h2, 16'h0000);
    wr(4'h0, 16'h0000);

    // R5 flag set, R6 handshake
    peek(4'h3, r); check("R5 flag0 set by match", r & 16'h0001, 16'h0001);
    wr(4'h3, 16'h0000);
    peek(4'h3, r); check("R6 zero write without read ignored", r & 16'h0001, 16'h0001);
    rd(4'h3, r);
    wr(4'h3, 16'h0000);
    peek(4'h3, r); check("R6 read-then-zero clears", r & 16'h0001, 16'h0000);

    // R8 zero transfer (mode 10): peak must not transfer
    wr(4'h4, 16'h0002);
    wr(4'h0, 16'h0002);
    wr(4'h2, 16'h0006);
    repeat (4) @(negedge clk);
    peek(4'hC, r); check("R8 mode 10 ignores peak", r, 16'h0003);
    repeat (3) @(negedge clk);
    peek(4'hC, r); check("R8 zero transfer", r, 16'h0002);
    wr(4'h2, 16'h0000);

    // R8 mode 00: no transfer
    wr(4'h4, 16'h0007);
    wr(4'h0, 16'h0000);
    wr(4'h2, 16'h0004);
    repeat (12) @(negedge clk);
    peek(4'hC, r); check("R8 mode 00 no transfer", r, 16'h0002);
    wr(4'h2, 16'h0000);

    // R8 mode 11: both events transfer
    wr(4'h5, 16'h0009);
    wr(4'h0, 16'h0002);
    wr(4'h2, 16'h0007);
    repeat (3) @(negedge clk);
    peek(4'hD, r); check("R8 mode 11 peak transfer", r, 16'h0009);
    wr(4'h5, 16'h000A);
    peek(4'hD, r); check("R3 compare held after deferred write", r, 16'h0009);
    repeat (3) @(negedge clk);
    peek(4'hD, r); check("R8 mode 11 zero transfer", r, 16'h000A);
    wr(4'h2, 16'h0000);

    // R9 set wins over clear
    wr(4'h0, 16'h0040);
    wr(4'hA, 16'h0040);
    rd(4'h3, r); check("R5 flag2 set by standing match", r & 16'h0004, 16'h0004);
    wr(4'h3, 16'h0000);
    peek(4'h3, r); check("R9 set beats clear", r & 16'h0004, 16'h0004);
    wr(4'h0, 16'h0041);
    rd(4'h3, r);
    wr(4'h3, 16'h0000);
    peek(4'h3, r); check("R6 clear after match gone", r & 16'h0004, 16'h0000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule